// File: doc/BRIEF.md
# Flash Unlock and Mass-Erase Sequencer

This block is the register front end of an on-chip flash array. Software reaches it over a simple 32-bit word bus that carries an address, write data, a write enable, a read enable and combinational read data. It holds four registers: a key port, a status word, a command word and an option word. The option word carries one not-write-protect bit per sector.

The command word comes out of reset locked. It accepts writes only after two specific key words have been written back to back to the key port. Once unlocked, software selects mass erase and sets the start bit. If every sector is unprotected, the sequencer raises a busy flag for a fixed number of cycles, which stands in for the array. When the count runs out, busy drops, the start bit clears, an end-of-operation flag is latched and a one-cycle done pulse goes out. If any sector is protected, the erase is refused: a sticky protection error is latched and the start bit never takes effect. Software can relock the command word at any time by writing its top bit.

Register offsets (byte address, word aligned): key 0x0, status 0x4, command 0x8, option 0xC. Unmapped offsets read as zero.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset the command word reads 0x80000000 (bit 31 lock set), the status word reads 0, the option word reads 0x0FFFAAED, and busy and done are low.
- R2: Lock clears only when the key port receives 0x45670123 and then 0xCDEF89AB as the very next key-port write.
- R3: Any other key value while locked, including the two keys in the wrong order or with a different key write between them, restarts the key sequence and leaves lock set.
- R4: While locked, writes to the command word are ignored and raise no error. While unlocked, writing 1 to bit 31 of the command word relocks it.
- R5: Reads of the key port always return 0.
- R6: A command write with bit 2 (mass erase) and bit 16 (start) both set, while unlocked, idle and with all sectors unprotected, raises busy for ERASE_CYCLES cycles with bit 16 reading 1. In the cycle busy drops, bit 16 clears, status bit 0 (end of operation) sets and the done pulse is high for exactly one cycle.
- R7: The same request with any not-write-protect bit at 0 starts nothing. It sets status bit 4 (protection error), and the command word reads 0x00000004.
- R8: Status bits 0 and 4 are sticky and clear only when 1 is written to them. Status bit 16 reads busy.
- R9: The option word's not-write-protect field (bits 27:16, 1 = sector unprotected) changes only on a write made while the command word is unlocked and option bit 0 is already 0. An option write made while unlocked updates bit 0. RDP and the other low bits are fixed.
- R10: Command writes made while busy are ignored.
- R11: A start request without bit 2 set starts nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the register |
| busWrData | input | 32 | Write data |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read enable; read data is zero when low |
| busRdData | output | 32 | Combinational read data |
| eraseBusy | output | 1 | High while an accepted erase counts down |
| eraseDone | output | 1 | One-cycle pulse as the erase finishes |

## Verification
The properties assume that each write is a single-cycle strobe with the address and data stable in that cycle, and that no writes arrive during reset. They also assume that reads never change state, so a read and a write in the same cycle need no ordering. The stimulus drives every bus field on the falling edge, holds each write for one full cycle, and leaves the bus idle between operations. A behavioural model in the bench follows the same cycle rules and is checked against busy and done on every clock and against the register contents after each step.

// File: rtl/fec_pkg.sv
package fec_pkg;
  localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
  localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

  localparam int OFF_KEY  = 'h0;
  localparam int OFF_STAT = 'h4;
  localparam int OFF_CMD  = 'h8;
  localparam int OFF_OPT  = 'hC;

  // fixed option-word fields
  localparam logic [7:0] RDP_LEVEL  = 8'hAA;
  localparam logic [6:0] OPT_FIXED  = 7'b1110110;

  // command-word bit positions
  localparam int CMD_LOCK  = 31;
  localparam int CMD_START = 16;
  localparam int CMD_MASS  = 2;

  // status-word bit positions
  localparam int ST_EOP  = 0;
  localparam int ST_WPE  = 4;
  localparam int ST_BUSY = 16;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_KEY, SEL_STAT, SEL_CMD, SEL_OPT
  } regSel_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic merLoad;
    logic merVal;
    logic launch;
    logic wrpHit;
    logic opDone;
    logic optLoad;
  } fecStrobe_t;
endpackage

// File: rtl/fec_bus_decode.sv
module fec_bus_decode
  import fec_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output logic              keyWr,
  output logic              statWr,
  output logic              cmdWr,
  output logic              optWr,
  output regSel_t           rdSel
);
  always_comb begin
    rdSel = SEL_NONE;
    case (int'(busAddr))
      OFF_KEY:  rdSel = SEL_KEY;
      OFF_STAT: rdSel = SEL_STAT;
      OFF_CMD:  rdSel = SEL_CMD;
      OFF_OPT:  rdSel = SEL_OPT;
      default:  rdSel = SEL_NONE;
    endcase
  end

  assign keyWr  = busWrEn && (rdSel == SEL_KEY);
  assign statWr = busWrEn && (rdSel == SEL_STAT);
  assign cmdWr  = busWrEn && (rdSel == SEL_CMD);
  assign optWr  = busWrEn && (rdSel == SEL_OPT);
endmodule

// File: rtl/fec_control.sv
module fec_control
  import fec_pkg::*;
#(
  parameter int ERASE_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        keyWr,
  input  logic        cmdWr,
  input  logic        optWr,
  input  logic [31:0] wrData,
  input  logic        anyProt,
  output logic        lockQ,
  output logic        busyQ,
  output logic        doneQ,
  output fecStrobe_t  stb
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

  typedef enum logic { KS_IDLE, KS_HALF } keyState_t;

  keyState_t         keyState;
  logic [CNT_W-1:0]  cnt;
  logic              cmdAccept;
  logic              eraseReq;
  logic              lastTick;

  assign cmdAccept = cmdWr && !lockQ && !busyQ;
  assign eraseReq  = cmdAccept && wrData[CMD_START] && wrData[CMD_MASS];
  assign lastTick  = busyQ && (cnt == CNT_W'(1));

  always_comb begin
    stb.merLoad = cmdAccept;
    stb.merVal  = wrData[CMD_MASS];
    stb.launch  = eraseReq && !anyProt;
    stb.wrpHit  = eraseReq && anyProt;
    stb.opDone  = lastTick;
    stb.optLoad = optWr && !lockQ;
  end

  // unlock sequence and relock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lockQ    <= 1'b1;
      keyState <= KS_IDLE;
    end else begin
      if (keyWr && lockQ) begin
        if (keyState == KS_IDLE && wrData == KEY_FIRST) begin
          keyState <= KS_HALF;
        end else if (keyState == KS_HALF && wrData == KEY_SECOND) begin
          keyState <= KS_IDLE;
          lockQ    <= 1'b0;
        end else begin
          keyState <= KS_IDLE;
        end
      end
      if (cmdAccept && wrData[CMD_LOCK]) begin
        lockQ    <= 1'b1;
        keyState <= KS_IDLE;
      end
    end
  end

  // erase countdown standing in for the array
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      cnt   <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= lastTick;
      if (stb.launch) begin
        busyQ <= 1'b1;
        cnt   <= CNT_W'(ERASE_CYCLES);
      end else if (busyQ) begin
        cnt <= cnt - CNT_W'(1);
        if (lastTick) busyQ <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fec_datapath.sv
module fec_datapath
  import fec_pkg::*;
#(
  parameter int NUM_SECTORS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  fecStrobe_t  stb,
  input  logic        statWr,
  input  logic [31:0] wrData,
  input  logic        busRdEn,
  input  regSel_t     rdSel,
  input  logic        lockQ,
  input  logic        busyQ,
  output logic        anyProt,
  output logic        wpErrQ,
  output logic [31:0] rdData
);
  logic                   eopQ;
  logic                   merQ;
  logic                   startQ;
  logic                   optLockQ;
  logic [NUM_SECTORS-1:0] nwpQ;
  logic [31:0]            statWord;
  logic [31:0]            cmdWord;
  logic [31:0]            optWord;

  assign anyProt = !(&nwpQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eopQ     <= 1'b0;
      wpErrQ   <= 1'b0;
      merQ     <= 1'b0;
      startQ   <= 1'b0;
      optLockQ <= 1'b1;
      nwpQ     <= '1;
    end else begin
      if (stb.opDone) eopQ <= 1'b1;
      else if (statWr && wrData[ST_EOP]) eopQ <= 1'b0;

      if (stb.wrpHit) wpErrQ <= 1'b1;
      else if (statWr && wrData[ST_WPE]) wpErrQ <= 1'b0;

      if (stb.merLoad) merQ <= stb.merVal;

      if (stb.launch) startQ <= 1'b1;
      else if (stb.opDone) startQ <= 1'b0;

      if (stb.optLoad) begin
        if (!optLockQ) nwpQ <= wrData[16 +: NUM_SECTORS];
        optLockQ <= wrData[0];
      end
    end
  end

  always_comb begin
    statWord           = '0;
    statWord[ST_EOP]   = eopQ;
    statWord[ST_WPE]   = wpErrQ;
    statWord[ST_BUSY]  = busyQ;

    cmdWord            = '0;
    cmdWord[CMD_LOCK]  = lockQ;
    cmdWord[CMD_START] = startQ;
    cmdWord[CMD_MASS]  = merQ;

    optWord                    = {16'h0000, RDP_LEVEL, OPT_FIXED, optLockQ};
    optWord[16 +: NUM_SECTORS] = nwpQ;
  end

  always_comb begin
    rdData = '0;
    if (busRdEn) begin
      case (rdSel)
        SEL_STAT: rdData = statWord;
        SEL_CMD:  rdData = cmdWord;
        SEL_OPT:  rdData = optWord;
        default:  rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import fec_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int NUM_SECTORS  = 12,
  parameter int ERASE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  output logic              eraseBusy,
  output logic              eraseDone
);
  logic       keyWr, statWr, cmdWr, optWr;
  regSel_t    rdSel;
  fecStrobe_t stb;
  logic       lockSig, busySig, anyProt, wpErrSig;

  fec_bus_decode #(.ADDR_W(ADDR_W)) uDec (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .keyWr   (keyWr),
    .statWr  (statWr),
    .cmdWr   (cmdWr),
    .optWr   (optWr),
    .rdSel   (rdSel)
  );

  fec_control #(.ERASE_CYCLES(ERASE_CYCLES)) uCtl (
    .clk     (clk),
    .rst_n   (rst_n),
    .keyWr   (keyWr),
    .cmdWr   (cmdWr),
    .optWr   (optWr),
    .wrData  (busWrData),
    .anyProt (anyProt),
    .lockQ   (lockSig),
    .busyQ   (busySig),
    .doneQ   (eraseDone),
    .stb     (stb)
  );

  fec_datapath #(.NUM_SECTORS(NUM_SECTORS)) uDp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .statWr  (statWr),
    .wrData  (busWrData),
    .busRdEn (busRdEn),
    .rdSel   (rdSel),
    .lockQ   (lockSig),
    .busyQ   (busySig),
    .anyProt (anyProt),
    .wpErrQ  (wpErrSig),
    .rdData  (busRdData)
  );

  assign eraseBusy = busySig;
endmodule

// File: rtl/fec_checker.sv
module fec_checker
  import fec_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int ERASE_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWrData,
  input logic              busWrEn,
  input logic              lockQ,
  input logic              busyQ,
  input logic              anyProt,
  input logic              wpErrQ,
  input logic              eraseDone
);
  logic [31:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rst_n) busyRun <= '0;
    else if (busyQ) busyRun <= busyRun + 32'd1;
    else busyRun <= '0;
  end

  // R2: lock falls only right after the second key lands on the key port
  a_r2_unlock_by_key: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lockQ) |-> $past(busWrEn && int'(busAddr) == OFF_KEY && busWrData == KEY_SECOND));

  // R4: a locked command write cannot start an erase
  a_r4_locked_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && int'(busAddr) == OFF_CMD && lockQ && !busyQ) |=> !busyQ);

  // R7: a protected mass-erase request flags the error and stays idle
  a_r7_protect_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && int'(busAddr) == OFF_CMD && !lockQ && !busyQ &&
     busWrData[CMD_START] && busWrData[CMD_MASS] && anyProt) |=> (!busyQ && wpErrQ));

  // R6: done pulses exactly as busy drops
  a_r6_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busyQ) |-> eraseDone);

  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eraseDone |-> !busyQ);

  // R6: busy lasts the programmed count
  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busyQ) |-> (busyRun == ERASE_CYCLES));
endmodule

bind flash_erase_ctrl fec_checker #(.ADDR_W(ADDR_W), .ERASE_CYCLES(ERASE_CYCLES)) uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .busWrEn   (busWrEn),
  .lockQ     (lockSig),
  .busyQ     (busySig),
  .anyProt   (anyProt),
  .wpErrQ    (wpErrSig),
  .eraseDone (eraseDone)
);

// File: tb/sim_flash_erase_ctrl.sv
module sim_flash_erase_ctrl;
  localparam int AW = 4;
  localparam int NCYC = 16;
  localparam logic [31:0] K1 = 32'h4567_0123;
  localparam logic [31:0] K2 = 32'hCDEF_89AB;
  localparam logic [3:0] A_KEY = 4'h0, A_ST = 4'h4, A_CMD = 4'h8, A_OPT = 4'hC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic busWrEn = 1'b0;
  logic busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic eraseBusy, eraseDone;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  flash_erase_ctrl #(.ADDR_W(AW), .NUM_SECTORS(12), .ERASE_CYCLES(NCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData),
    .eraseBusy(eraseBusy), .eraseDone(eraseDone)
  );

  // behavioural reference model
  bit mLock, mHalf, mBusy, mDone, mEop, mErr, mMer, mStart, mOptLock;
  int mCnt;
  bit [11:0] mNwp;

  always @(posedge clk) begin
    bit oldBusy;
    if (!rst_n) begin
      mLock = 1; mHalf = 0; mBusy = 0; mDone = 0; mEop = 0; mErr = 0;
      mMer = 0; mStart = 0; mOptLock = 1; mCnt = 0; mNwp = 12'hFFF;
    end else begin
      oldBusy = mBusy;
      mDone = 0;
      if (busWrEn && busAddr == A_ST) begin
        if (busWrData[0]) mEop = 0;
        if (busWrData[4]) mErr = 0;
      end
      if (oldBusy) begin
        mCnt = mCnt - 1;
        if (mCnt == 0) begin mBusy = 0; mStart = 0; mEop = 1; mDone = 1; end
      end
      if (busWrEn && busAddr == A_KEY && mLock) begin
        if (!mHalf && busWrData == K1) mHalf = 1;
        else if (mHalf && busWrData == K2) begin mHalf = 0; mLock = 0; end
        else mHalf = 0;
      end
      if (busWrEn && busAddr == A_CMD && !mLock && !oldBusy) begin
        mMer = busWrData[2];
        if (busWrData[31]) mLock = 1;
        if (busWrData[16] && busWrData[2]) begin
          if (mNwp != 12'hFFF) mErr = 1;
          else begin mStart = 1; mBusy = 1; mCnt = NCYC; end
        end
      end
      if (busWrEn && busAddr == A_OPT && !mLock) begin
        if (!mOptLock) mNwp = busWrData[27:16];
        mOptLock = busWrData[0];
      end
    end
  end

  function automatic logic [31:0] modelRead(logic [3:0] a);
    case (a)
      A_ST:  return {15'b0, mBusy, 11'b0, mErr, 3'b0, mEop};
      A_CMD: return {mLock, 14'b0, mStart, 13'b0, mMer, 2'b0};
      A_OPT: return {4'b0, mNwp, 8'hAA, 7'b1110110, mOptLock};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R6: busy and done follow the model on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      check("R6 busy", {31'b0, eraseBusy}, {31'b0, mBusy});
      check("R6 done", {31'b0, eraseDone}, {31'b0, mDone});
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rdExp(string tag, logic [3:0] a, logic [31:0] exp);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #2;
    check(tag, busRdData, exp);
    check({tag, " model"}, busRdData, modelRead(a));
    busRdEn = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        finishRun();
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 and R5: reset state
    rdExp("R1 cmd reset", A_CMD, 32'h8000_0000);
    rdExp("R1 stat reset", A_ST, 32'h0);
    rdExp("R1 opt reset", A_OPT, 32'h0FFF_AAED);
    rdExp("R5 key reads 0", A_KEY, 32'h0);

    // R4: locked command write ignored, no error
    wr(A_CMD, 32'h0001_0004);
    idle(2);
    rdExp("R4 locked cmd", A_CMD, 32'h8000_0000);
    rdExp("R4 no error", A_ST, 32'h0);

    // R3: broken sequences keep lock
    wr(A_KEY, K1); wr(A_KEY, 32'h0); wr(A_KEY, K2);
    rdExp("R3 interrupted", A_CMD, 32'h8000_0000);
    wr(A_KEY, K2); wr(A_KEY, K2);
    rdExp("R3 wrong order", A_CMD, 32'h8000_0000);
    wr(A_KEY, K1); wr(A_KEY, K1); wr(A_KEY, K2);
    rdExp("R3 double first", A_CMD, 32'h8000_0000);

    // R9: option writes ignored while locked
    wr(A_OPT, 32'h0000_0000);
    rdExp("R9 locked opt", A_OPT, 32'h0FFF_AAED);

    // R2: correct sequence unlocks
    wr(A_KEY, K1); wr(A_KEY, K2);
    rdExp("R2 unlocked", A_CMD, 32'h0);
    rdExp("R5 key after unlock", A_KEY, 32'h0);

    // R9: field frozen while option lock set, then writable
    wr(A_OPT, 32'h0AAA_0001);
    rdExp("R9 optlock holds", A_OPT, 32'h0FFF_AAED);
    wr(A_OPT, 32'h0AAA_0000);
    rdExp("R9 optlock clear", A_OPT, 32'h0FFF_AAEC);
    wr(A_OPT, 32'hFAAA_00FE);
    rdExp("R9 field written", A_OPT, 32'h0AAA_AAEC);

    // R7: protected erase refused
    wr(A_CMD, 32'h0001_0004);
    idle(3);
    rdExp("R7 cmd only mass", A_CMD, 32'h0000_0004);
    rdExp("R7 error set", A_ST, 32'h0000_0010);
    // R8: write-1-to-clear
    wr(A_ST, 32'h0000_0001);
    rdExp("R8 zero bit keeps err", A_ST, 32'h0000_0010);
    wr(A_ST, 32'h0000_0010);
    rdExp("R8 err cleared", A_ST, 32'h0);

    // R11: start without mass select
    wr(A_OPT, 32'h0FFF_0000);
    rdExp("R9 field restored", A_OPT, 32'h0FFF_AAEC);
    wr(A_CMD, 32'h0001_0000);
    idle(2);
    rdExp("R11 no start", A_CMD, 32'h0);
    rdExp("R11 no status", A_ST, 32'h0);

    // R6: accepted erase
    wr(A_CMD, 32'h0001_0004);
    rdExp("R6 started", A_CMD, 32'h0001_0004);
    rdExp("R6 busy status", A_ST, 32'h0001_0000);
    // R10: command write while busy ignored
    wr(A_CMD, 32'h8000_0000);
    rdExp("R10 ignored", A_CMD, 32'h0001_0004);
    idle(NCYC);
    rdExp("R6 finished cmd", A_CMD, 32'h0000_0004);
    rdExp("R6 eop set", A_ST, 32'h0000_0001);
    wr(A_ST, 32'h0000_0001);
    rdExp("R8 eop cleared", A_ST, 32'h0);

    // R4: relock via bit 31
    wr(A_CMD, 32'h8000_0000);
    rdExp("R4 relocked", A_CMD, 32'h8000_0000);
    wr(A_OPT, 32'h0000_0001);
    rdExp("R9 relocked opt", A_OPT, 32'h0FFF_AAEC);
    wr(A_KEY, K1); wr(A_KEY, K2);
    rdExp("R2 unlock again", A_CMD, 32'h0);

    // second erase back to back
    wr(A_CMD, 32'h0001_0004);
    idle(NCYC + 2);
    rdExp("R6 second eop", A_ST, 32'h0000_0001);

    idle(2);
    finishRun();
  end
endmodule